// File: doc/BRIEF.md
# Lock-Gated Debug Control Register

This block holds a 64-bit debug control word. A few of its bits are real storage inside the block: monitor-event enable, local debug enable, the channel-access trap for the least privileged level, and software step. Most of the other defined bits hold no state here. They are windows onto an external debug status register. Each window sits at the same bit position as its field in that external register. A read of a window always shows the external field's current value. A write reaches the external register only while the operating-system lock input is high. While the lock is low, writes to the windows are dropped.

A single write strobe carries a full 64-bit word. On that strobe the local bits are loaded at the next clock edge. In the same cycle, and only when the lock is set, the block raises a masked write towards the external register. Reads are combinational. Two feature parameters decide whether the trace-filter window (bit 31) and the sampling window (bit 19) exist. An input tells the block that the debug target level runs in the 32-bit execution state. While it is high, the local-enable and step bits read as zero.

Top module: `dbgctl_lockreg`

## Requirements
- R1: Bits 63:32 of `reg_rdata` always read zero, and writing ones to them changes nothing that can be observed.
- R2: The window bits 30, 29, 27, 26, 23:21, 14 and 6 of `reg_rdata` equal the same bits of `ext_rdata` in every cycle, whatever the state of `os_lock`.
- R3: When `reg_wr` and `os_lock` are both 1, `ext_wr` is 1 in that same cycle. `ext_wmask` then has exactly the window bits set (default mask 32'hECE0_4040), and `ext_wdata` carries `reg_wdata[31:0]` under that mask.
- R4: When `os_lock` is 0, `ext_wr` stays 0, so a write leaves every window bit of the external register unchanged.
- R5: Bits 28, 25:24, 20, 18:16, 11:7 and 5:1 always read zero, and writes to them are ignored.
- R6: On a `reg_wr` strobe, bits 15 and 12 take the written value and show it from the next cycle on. Without a strobe they hold their value. Local bits and external windows are both updated by one and the same strobe.
- R7: While `tgt_narrow` is 1, bits 13 and 0 read zero. Their stored value is kept and reads back once `tgt_narrow` returns to 0.
- R8: Bit 31 is a window only when `HAS_FILT_OVR` is 1, and bit 19 only when `HAS_SAMPLE_CTL` is 1. An absent window reads zero and is clear in `ext_wmask`. The defaults are 1 and 0.
- R9: After reset, bits 15, 13, 12 and 0 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| os_lock | input | 1 | Operating-system lock; 1 opens the windows for writing |
| tgt_narrow | input | 1 | Debug target level uses the 32-bit execution state |
| ext_rdata | input | 32 | Current value of the external debug status register |
| ext_wr | output | 1 | Write strobe to the external register |
| ext_wmask | output | 32 | Bits of the external register that the write touches |
| ext_wdata | output | 32 | Write data to the external register |

## Verification
Directed phases separate the two kinds of bits. An all-ones external value with the lock clear shows which positions are windows and which are reserved. An all-ones write with the lock clear must change only the local bits. A locked all-zeros write must clear only the windows and leave the external register's other bits set. The random phase then mixes strobes, lock, target state and external changes made by the debugger side, with a write and an external change sometimes landing in the same cycle. A behavioural model checks every field group each cycle.

// File: rtl/dbgctl_pkg.sv
package dbgctl_pkg;
   localparam int unsigned WIN_W = 32;
   // positions of locally stored bits
   localparam int unsigned POS_STEP      = 0;
   localparam int unsigned POS_CHAN_TRAP = 12;
   localparam int unsigned POS_LOCAL_EN  = 13;
   localparam int unsigned POS_MON_EN    = 15;
   // optional windows
   localparam int unsigned POS_FILT_OVR  = 31;
   localparam int unsigned POS_SAMPLE    = 19;
   // always-present windows: 30,29,27,26,23,22,21,14,6
   localparam logic [WIN_W-1:0] WIN_BASE   = 32'h6CE0_4040;
   localparam logic [WIN_W-1:0] LOCAL_KEEP = (32'd1 << POS_STEP) | (32'd1 << POS_CHAN_TRAP)
                                           | (32'd1 << POS_LOCAL_EN) | (32'd1 << POS_MON_EN);
   localparam logic [WIN_W-1:0] LOCAL_HIDE = (32'd1 << POS_STEP) | (32'd1 << POS_LOCAL_EN);

   function automatic logic [WIN_W-1:0] window_mask(input bit has_filt, input bit has_sample);
      logic [WIN_W-1:0] m;
      m = WIN_BASE;
      if (has_filt)   m[POS_FILT_OVR] = 1'b1;
      if (has_sample) m[POS_SAMPLE]   = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/dbgctl_local_bits.sv
module dbgctl_local_bits #(
   parameter int unsigned      W    = 32,
   parameter logic [W-1:0]     KEEP = '0,
   parameter logic [W-1:0]     HIDE = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         narrow,
   output logic [W-1:0] view
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      if (KEEP[b]) begin : g_store
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q <= 1'b0;
            else if (wr_en) q <= wr_data[b];
         end
         if (HIDE[b]) begin : g_hide
            assign view[b] = q & ~narrow;
         end else begin : g_show
            assign view[b] = q;
         end
      end else begin : g_none
         assign view[b] = 1'b0;
      end
   end
endmodule

// File: rtl/dbgctl_window_port.sv
module dbgctl_window_port #(
   parameter int unsigned  W    = 32,
   parameter logic [W-1:0] MASK = '0
) (
   input  logic         lock,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic [W-1:0] ext_rd,
   output logic         ext_wr,
   output logic [W-1:0] ext_wmask,
   output logic [W-1:0] ext_wdata,
   output logic [W-1:0] view
);
   // writes pass only while the lock is held; reads always pass
   assign ext_wr    = wr_en & lock;
   assign ext_wmask = MASK;
   assign ext_wdata = wr_data & MASK;
   assign view      = ext_rd & MASK;
endmodule

// File: rtl/dbgctl_read_join.sv
module dbgctl_read_join #(
   parameter int unsigned CTL_W = 64,
   parameter int unsigned W     = 32
) (
   input  logic [W-1:0]     local_view,
   input  logic [W-1:0]     win_view,
   output logic [CTL_W-1:0] rdata
);
   assign rdata[W-1:0] = local_view | win_view;
   if (CTL_W > W) begin : g_upper
      assign rdata[CTL_W-1:W] = '0;
   end
endmodule

// File: rtl/dbgctl_lockreg.sv
module dbgctl_lockreg
   import dbgctl_pkg::*;
#(
   parameter int unsigned CTL_W          = 64,
   parameter bit          HAS_FILT_OVR   = 1'b1,
   parameter bit          HAS_SAMPLE_CTL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [CTL_W-1:0]  reg_wdata,
   output logic [CTL_W-1:0]  reg_rdata,
   input  logic              os_lock,
   input  logic              tgt_narrow,
   input  logic [WIN_W-1:0]  ext_rdata,
   output logic              ext_wr,
   output logic [WIN_W-1:0]  ext_wmask,
   output logic [WIN_W-1:0]  ext_wdata
);
   localparam logic [WIN_W-1:0] WMASK = window_mask(HAS_FILT_OVR, HAS_SAMPLE_CTL);

   if (CTL_W < WIN_W) begin : g_bad_width
      $error("dbgctl_lockreg: CTL_W must be at least %0d", WIN_W);
   end
   if ((WMASK & LOCAL_KEEP) != '0) begin : g_bad_overlap
      $error("dbgctl_lockreg: window and local bit sets overlap");
   end

   logic [WIN_W-1:0] local_view;
   logic [WIN_W-1:0] win_view;

   dbgctl_local_bits #(.W(WIN_W), .KEEP(LOCAL_KEEP), .HIDE(LOCAL_HIDE)) u_local (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .wr_data (reg_wdata[WIN_W-1:0]),
      .narrow  (tgt_narrow),
      .view    (local_view)
   );

   dbgctl_window_port #(.W(WIN_W), .MASK(WMASK)) u_win (
      .lock      (os_lock),
      .wr_en     (reg_wr),
      .wr_data   (reg_wdata[WIN_W-1:0]),
      .ext_rd    (ext_rdata),
      .ext_wr    (ext_wr),
      .ext_wmask (ext_wmask),
      .ext_wdata (ext_wdata),
      .view      (win_view)
   );

   dbgctl_read_join #(.CTL_W(CTL_W), .W(WIN_W)) u_join (
      .local_view (local_view),
      .win_view   (win_view),
      .rdata      (reg_rdata)
   );
endmodule

// File: rtl/dbgctl_chk.sv
module dbgctl_chk
   import dbgctl_pkg::*;
#(
   parameter int unsigned CTL_W          = 64,
   parameter bit          HAS_FILT_OVR   = 1'b1,
   parameter bit          HAS_SAMPLE_CTL = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [CTL_W-1:0] reg_rdata,
   input logic             os_lock,
   input logic             tgt_narrow,
   input logic [WIN_W-1:0] ext_rdata,
   input logic             ext_wr
);
   localparam logic [WIN_W-1:0] RSVD = ~(WIN_BASE | LOCAL_KEEP
                                        | (32'd1 << POS_FILT_OVR) | (32'd1 << POS_SAMPLE));

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[CTL_W-1:WIN_W] == '0); // R1
   AST_WIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[WIN_W-1:0] & WIN_BASE) == (ext_rdata & WIN_BASE)); // R2
   AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && os_lock) |-> ext_wr); // R3
   AST_NO_UNLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !os_lock |-> !ext_wr); // R4
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[WIN_W-1:0] & RSVD) == '0); // R5
   AST_LOCAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> ($stable(reg_rdata[POS_MON_EN]) && $stable(reg_rdata[POS_CHAN_TRAP]))); // R6
   AST_NARROW_HIDE: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_narrow |-> (reg_rdata[POS_LOCAL_EN] == 1'b0 && reg_rdata[POS_STEP] == 1'b0)); // R7
   AST_OPT_BIT31: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[POS_FILT_OVR] == (HAS_FILT_OVR ? ext_rdata[POS_FILT_OVR] : 1'b0)); // R8
   AST_OPT_BIT19: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[POS_SAMPLE] == (HAS_SAMPLE_CTL ? ext_rdata[POS_SAMPLE] : 1'b0)); // R8
endmodule

bind dbgctl_lockreg dbgctl_chk #(
   .CTL_W(CTL_W), .HAS_FILT_OVR(HAS_FILT_OVR), .HAS_SAMPLE_CTL(HAS_SAMPLE_CTL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
   .os_lock(os_lock), .tgt_narrow(tgt_narrow), .ext_rdata(ext_rdata), .ext_wr(ext_wr)
);

// File: tb/sim_dbgctl_lockreg.sv
module sim_dbgctl_lockreg;
   // 125 MHz clock: 8 ns period, half period 4
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        os_lock = 1'b0;
   logic        tgt_narrow = 1'b0;
   logic [31:0] ext_q;
   logic        ext_wr;
   logic [31:0] ext_wmask, ext_wdata;
   logic        poke_en = 1'b0;
   logic [31:0] poke_val = '0;
   logic        run_chk = 1'b0;

   int checks = 0;
   int errors = 0;

   // expectations taken from the requirements (defaults: bit 31 window, bit 19 absent)
   localparam logic [31:0] M_WIN   = 32'hECE0_4040; // R3
   localparam logic [31:0] M_BASE  = 32'h6CE0_4040; // R2
   localparam logic [31:0] M_OPT   = 32'h8008_0000; // R8: bits 31 and 19
   localparam logic [31:0] M_RSVD  = 32'h1317_0FBE; // R5
   localparam logic [31:0] M_LOC   = 32'h0000_9000; // R6: bits 15, 12
   localparam logic [31:0] M_NAR   = 32'h0000_2001; // R7: bits 13, 0

   always #4 clk = ~clk;

   dbgctl_lockreg u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .os_lock(os_lock), .tgt_narrow(tgt_narrow),
      .ext_rdata(ext_q), .ext_wr(ext_wr), .ext_wmask(ext_wmask), .ext_wdata(ext_wdata)
   );

   // external status register environment: applies the block's writes
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ext_q <= '0;
      else if (poke_en) ext_q <= poke_val;
      else if (ext_wr)  ext_q <= (ext_q & ~ext_wmask) | (ext_wdata & ext_wmask);
   end

   // behavioural reference, driven by the stimulus only
   logic [31:0] mdl_loc, mdl_ext;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdl_loc = '0;
         mdl_ext = '0;
      end else begin
         if (reg_wr) mdl_loc = reg_wdata[31:0] & 32'h0000_B001;
         if (poke_en) mdl_ext = poke_val;
         else if (reg_wr && os_lock) mdl_ext = (mdl_ext & ~M_WIN) | (reg_wdata[31:0] & M_WIN);
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   logic [31:0] exp_lo;
   always @(negedge clk) begin
      if (rst_n && run_chk) begin
         exp_lo = (mdl_ext & M_WIN) | (mdl_loc & (tgt_narrow ? ~M_NAR : 32'hFFFF_FFFF));
         chk("R1 upper",      {32'h0, reg_rdata[63:32]}, 64'h0);
         chk("R2 windows",    {32'h0, reg_rdata[31:0] & M_BASE}, {32'h0, exp_lo & M_BASE});
         chk("R8 optional",   {32'h0, reg_rdata[31:0] & M_OPT},  {32'h0, exp_lo & M_OPT});
         chk("R5 reserved",   {32'h0, reg_rdata[31:0] & M_RSVD}, 64'h0);
         chk("R6 local",      {32'h0, reg_rdata[31:0] & M_LOC},  {32'h0, exp_lo & M_LOC});
         chk("R7 narrow",     {32'h0, reg_rdata[31:0] & M_NAR},  {32'h0, exp_lo & M_NAR});
         chk("R3 ext state",  {32'h0, ext_q}, {32'h0, mdl_ext});
         if (!os_lock) chk("R4 no write", {63'h0, ext_wr}, 64'h0);
         if (reg_wr && os_lock) begin
            chk("R3 strobe", {63'h0, ext_wr}, 64'h1);
            chk("R3 mask",   {32'h0, ext_wmask}, {32'h0, M_WIN});
            chk("R3 data",   {32'h0, ext_wdata & M_WIN}, {32'h0, reg_wdata[31:0] & M_WIN});
         end
      end
   end

   task automatic drive(input logic wr, input logic [63:0] d, input logic lk,
                        input logic nar, input logic pk, input logic [31:0] pv);
      @(posedge clk);
      #1;
      reg_wr = wr; reg_wdata = d; os_lock = lk; tgt_narrow = nar;
      poke_en = pk; poke_val = pv;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R9 reset", reg_rdata, 64'h0);
      run_chk = 1'b1;
      // expose the window positions, lock clear
      drive(0, '0, 0, 0, 1, 32'hFFFF_FFFF);
      drive(0, '0, 0, 0, 0, '0);
      @(negedge clk);
      chk("R8 window pattern", reg_rdata, {32'h0, M_WIN});
      // unlocked all-ones write: local bits only
      drive(1, {64{1'b1}}, 0, 0, 0, '0);
      drive(0, '0, 0, 0, 0, '0);
      @(negedge clk);
      chk("R4 unlocked write", reg_rdata, {32'h0, M_WIN | 32'h0000_B001});
      chk("R1 upper ignored", {32'h0, reg_rdata[63:32]}, 64'h0);
      // narrow hides bits 13, 0 and keeps them
      drive(0, '0, 0, 1, 0, '0);
      @(negedge clk);
      chk("R7 hidden", {32'h0, reg_rdata[31:0] & M_NAR}, 64'h0);
      drive(0, '0, 0, 0, 0, '0);
      @(negedge clk);
      chk("R7 restored", {32'h0, reg_rdata[31:0] & M_NAR}, {32'h0, M_NAR});
      // locked all-zeros write: windows cleared, other external bits kept
      drive(1, '0, 1, 0, 0, '0);
      drive(0, '0, 1, 0, 0, '0);
      @(negedge clk);
      chk("R3 locked clear", {32'h0, ext_q}, {32'h0, ~M_WIN});
      chk("R6 same strobe", reg_rdata, 64'h0);
      // random mix
      void'($urandom(32'd11));
      for (int i = 0; i < 400; i++) begin
         drive($urandom % 2 == 0, {$urandom, $urandom}, $urandom % 2 == 0,
               $urandom % 4 == 0, $urandom % 8 == 0, $urandom);
      end
      drive(0, '0, 0, 0, 0, '0);
      @(negedge clk);
      run_chk = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog (all of R1..R9 unfinished): actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule